// File: doc/BRIEF.md
# Dual-Style Microprocessor Register Port

This block is the slave side of an 8-bit processor bus. It gives a host access to a bank of 32 internal 8-bit registers. Two static inputs set up the port. The first chooses between an Intel-style bus, with separate read and write strobes, and a Motorola-style bus, with a read/write line and a data strobe. The second chooses whether the address travels on the shared address/data lines or on a separate address input.

Every bus input first passes through a two-flop synchronizer into the system clock domain. Strobe edges are then found on the synchronized copies. A write is committed to the register bank on the closing (rising) edge of the write strobe or data strobe. Only one write is accepted for each low period of chip select. Read data is driven on a data output with a separate enable, so the surrounding pad logic can release the bus. The contents of every register are also brought out in parallel for the logic around the port.

Top module: `hbus_port`

## Requirements
- R1: After reset all 32 registers read 0, `ad_oe` is 0 and `ad_out` is 0.
- R2: With `mode_intel`=1 and `mode_mux`=1, the address is taken from `ad_in[4:0]` when `ale_as` falls. While `cs_n` is low, a rising edge on `wr_ds` (the write strobe, active low) writes `ad_in` into the addressed register.
- R3: In multiplexed mode, `ad_in[7:5]` has no effect on address capture. A write addressed as 0xE5 updates register 5.
- R4: With `mode_intel`=0 and `mode_mux`=1, the address is taken from `ad_in[4:0]` when `ale_as` (the address strobe, active low) falls. A rising edge on `wr_ds` (the data strobe, active low) while `rd_rw`=0 and `cs_n` is low performs a write.
- R5: Only one write is accepted per chip-select low period. A further strobe is ignored until `cs_n` has gone high and then low again.
- R6: A strobe edge while `cs_n` is high changes no register.
- R7: With `mode_mux`=0, the address comes from `addr_in`, which is sampled while `cs_n` is low. Edges on `ale_as` have no effect.
- R8: `ad_oe` is 1 only while `cs_n` is low and a read is qualified, and `ad_out` then carries the addressed register. A read is qualified by `rd_rw`=0 (the read strobe) in Intel mode, and by `rd_rw`=1 together with `wr_ds`=0 in Motorola mode. At all other times `ad_oe` and `ad_out` are 0.
- R9: `reg_out[8*n+7:8*n]` always shows the value of register n.
- R10: In Motorola mode, holding `wr_ds` low with `rd_rw`=0 does not assert `ad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_intel | input | 1 | 1 selects Intel-style strobes, 0 selects Motorola-style strobes |
| mode_mux | input | 1 | 1 selects a multiplexed address/data bus, 0 selects a separate address input |
| cs_n | input | 1 | Chip select, active low |
| ale_as | input | 1 | Address latch enable (Intel) or address strobe, active low (Motorola); the address is captured on its falling edge |
| rd_rw | input | 1 | Read strobe, active low (Intel), or read/write line, 1 for read (Motorola) |
| wr_ds | input | 1 | Write strobe, active low (Intel), or data strobe, active low (Motorola) |
| ad_in | input | 8 | Address/data bus input |
| addr_in | input | 5 | Register address used in non-multiplexed mode |
| ad_out | output | 8 | Read data |
| ad_oe | output | 1 | Enable for the read data drivers |
| reg_out | output | 256 | All registers side by side, register n in bits 8n+7..8n |

## Verification
The bench builds the block with its default parameters: 8 data bits, 5 address bits (32 registers) and two synchronizer stages. With this setup the whole register space can be reached. That includes the top register 31 and the aliasing of the upper three bus bits onto addresses below 32. All four combinations of bus style and multiplexing are run, along with the single-write-per-select rule.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    typedef enum logic {
        BUS_MOTO  = 1'b0,
        BUS_INTEL = 1'b1
    } bus_style_e;

    // positions of control lines inside the synchronized vector
    localparam int unsigned SI_CS   = 0;
    localparam int unsigned SI_ALE  = 1;
    localparam int unsigned SI_RDRW = 2;
    localparam int unsigned SI_STRB = 3;
    localparam int unsigned SI_CTRL = 4;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = chain_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= stage_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned NREG  = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [ADDR_W-1:0]      raddr,
    output logic [DATA_W-1:0]      rdata,
    output logic [NREG*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] mem_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DATA_W-1:0] mem_d;
        always_comb begin
            mem_d = mem_q[i];
            if (we && (waddr == ADDR_W'(i))) mem_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d;
        end
        assign regs_flat[i*DATA_W +: DATA_W] = mem_q[i];
    end

    assign rdata = mem_q[raddr];

    // R6: without a write enable no register may change
    a_r6_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_style_e        style,
    input  logic              mux_bus,
    input  logic              s_cs_n,
    input  logic              s_ale,
    input  logic              s_rdrw,
    input  logic              s_strb,
    input  logic [DATA_W-1:0] s_ad,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);
    typedef struct packed {
        logic              cs_p;
        logic              ale_p;
        logic              strb_p;
        logic              armed;
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic [DATA_W-1:0] rdat;
    } dec_t;

    dec_t q, d;
    logic cs_act, cs_fall, ale_fall, strb_rise, wr_fire, rd_qual;

    always_comb begin
        cs_act    = !s_cs_n;
        cs_fall   = cs_act && q.cs_p;
        ale_fall  = q.ale_p && !s_ale;
        strb_rise = s_strb && !q.strb_p;
        if (style == BUS_INTEL) begin
            wr_fire = strb_rise && cs_act && q.armed;
            rd_qual = !s_rdrw;
        end else begin
            wr_fire = strb_rise && cs_act && q.armed && !s_rdrw;
            rd_qual = s_rdrw && !s_strb;
        end

        d        = q;
        d.cs_p   = s_cs_n;
        d.ale_p  = s_ale;
        d.strb_p = s_strb;

        if (s_cs_n)       d.armed = 1'b0;
        else if (cs_fall) d.armed = 1'b1;
        else if (wr_fire) d.armed = 1'b0;

        if (mux_bus) begin
            if (ale_fall) d.addr = s_ad[ADDR_W-1:0];
        end else if (cs_act) begin
            d.addr = s_addr;
        end

        d.oe   = cs_act && rd_qual;
        d.rdat = (cs_act && rd_qual) ? rf_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs_p   <= 1'b1;
            q.strb_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rf_we    = wr_fire;
    assign rf_addr  = q.addr;
    assign rf_wdata = s_ad;
    assign rd_data  = q.rdat;
    assign rd_oe    = q.oe;

    // R5: a write consumes the select period
    a_r5_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !q.armed);
    // R3: in multiplexed mode the address moves only on an address strobe fall
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_bus && !ale_fall && $stable(mux_bus)) |=> $stable(q.addr));
    // R8: released output carries no data
    a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> (rd_data == '0));
endmodule

// File: rtl/hbus_port.sv
module hbus_port
    import hbus_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NREG       = 1 << ADDR_W,
    localparam int unsigned SW         = SI_CTRL + DATA_W + ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_intel,
    input  logic                   mode_mux,
    input  logic                   cs_n,
    input  logic                   ale_as,
    input  logic                   rd_rw,
    input  logic                   wr_ds,
    input  logic [DATA_W-1:0]      ad_in,
    input  logic [ADDR_W-1:0]      addr_in,
    output logic [DATA_W-1:0]      ad_out,
    output logic                   ad_oe,
    output logic [NREG*DATA_W-1:0] reg_out
);
    localparam logic [SW-1:0] SYNC_RST = SW'((1 << SI_CS) | (1 << SI_RDRW) | (1 << SI_STRB));

    logic [SW-1:0]     raw, syn;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata;
    bus_style_e        style;

    assign raw   = {addr_in, ad_in, wr_ds, rd_rw, ale_as, cs_n};
    assign style = mode_intel ? BUS_INTEL : BUS_MOTO;

    hbus_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(syn));

    hbus_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dec (
        .clk(clk), .rst_n(rst_n), .style(style), .mux_bus(mode_mux),
        .s_cs_n(syn[SI_CS]), .s_ale(syn[SI_ALE]), .s_rdrw(syn[SI_RDRW]),
        .s_strb(syn[SI_STRB]), .s_ad(syn[SI_CTRL +: DATA_W]),
        .s_addr(syn[SI_CTRL+DATA_W +: ADDR_W]), .rf_rdata(rdata),
        .rf_we(we), .rf_addr(addr), .rf_wdata(wdata),
        .rd_data(ad_out), .rd_oe(ad_oe));

    hbus_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(addr), .wdata(wdata),
        .raddr(addr), .rdata(rdata), .regs_flat(reg_out));

    // R8: chip select held high long enough to pass the synchronizer releases the bus
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !ad_oe);
endmodule

// File: tb/test_hbus_port.sv
module test_hbus_port;
    logic        clk = 0, rst_n = 0;
    logic        mode_intel = 1, mode_mux = 1;
    logic        cs_n = 1, ale_as = 0, rd_rw = 1, wr_ds = 1;
    logic [7:0]  ad_in = 0;
    logic [4:0]  addr_in = 0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [255:0] reg_out;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    hbus_port i_hbus_port (.clk, .rst_n, .mode_intel, .mode_mux, .cs_n, .ale_as,
        .rd_rw, .wr_ds, .ad_in, .addr_in, .ad_out, .ad_oe, .reg_out);

    task automatic w(int n = 5); repeat (n) @(negedge clk); endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic [7:0] rg(int n); return reg_out[n*8 +: 8]; endfunction

    task automatic setup(bit intel, bit mux);
        rst_n = 0; mode_intel = intel; mode_mux = mux;
        cs_n = 1; ale_as = intel ? 1'b0 : 1'b1; rd_rw = 1; wr_ds = 1;
        w(3); rst_n = 1; w(3);
    endtask

    task automatic addr_phase(logic [7:0] a);
        if (mode_mux) begin
            ad_in = a; ale_as = ~ale_as; w();
            if (mode_intel) ale_as = 0; else begin ale_as = 1; w(); ale_as = 0; end
            w(); if (!mode_intel) ale_as = 1;
        end else begin
            addr_in = a[4:0]; w();
        end
    endtask

    // one write access; extra = a second strobe inside the same select
    task automatic bus_wr(logic [7:0] a, logic [7:0] dat, bit extra = 0, logic [7:0] dat2 = 0);
        if (!mode_mux) begin addr_in = a[4:0]; w(); end
        cs_n = 0; w();
        addr_phase(a);
        ad_in = dat; if (!mode_intel) rd_rw = 0; w();
        wr_ds = 0; w(); wr_ds = 1; w();
        if (extra) begin ad_in = dat2; wr_ds = 0; w(); wr_ds = 1; w(); end
        rd_rw = 1; cs_n = 1; w();
    endtask

    task automatic bus_rd(logic [7:0] a, logic [7:0] exp, string tag);
        if (!mode_mux) begin addr_in = a[4:0]; w(); end
        cs_n = 0; w();
        addr_phase(a);
        ad_in = 8'h00;
        if (mode_intel) rd_rw = 0; else begin rd_rw = 1; wr_ds = 0; end
        w();
        chk(ad_oe === 1'b1, {tag, " oe"}, ad_oe, 1);
        chk(ad_out === exp, {tag, " data"}, ad_out, exp);
        rd_rw = 1; wr_ds = 1; w();
        chk(ad_oe === 1'b0, {tag, " release"}, ad_oe, 0);
        cs_n = 1; w();
    endtask

    task automatic t_reset;   // R1
        setup(1, 1);
        chk(reg_out === '0, "R1 regs", reg_out[31:0], 0);
        chk(ad_oe === 1'b0, "R1 oe", ad_oe, 0);
        chk(ad_out === 8'h00, "R1 out", ad_out, 0);
    endtask

    task automatic t_intel_mux;   // R2 R3 R9
        setup(1, 1);
        bus_wr(8'h07, 8'h3C);
        chk(rg(7) === 8'h3C, "R2 write reg7", rg(7), 8'h3C);
        bus_wr(8'h1F, 8'hA5);
        chk(rg(31) === 8'hA5, "R9 reg31 lane", rg(31), 8'hA5);
        bus_wr(8'hE5, 8'h5A);
        chk(rg(5) === 8'h5A, "R3 upper bits ignored", rg(5), 8'h5A);
        bus_rd(8'h07, 8'h3C, "R2 read reg7");
        bus_rd(8'hFF, 8'hA5, "R3 read alias 31");
    endtask

    task automatic t_moto_mux;   // R4 R10
        setup(0, 1);
        bus_wr(8'h0A, 8'hC3);
        chk(rg(10) === 8'hC3, "R4 write reg10", rg(10), 8'hC3);
        bus_rd(8'h0A, 8'hC3, "R4 read reg10");
        cs_n = 0; w(); rd_rw = 0; wr_ds = 0; w();
        chk(ad_oe === 1'b0, "R10 write qual no oe", ad_oe, 0);
        wr_ds = 1; rd_rw = 1; cs_n = 1; w();
    endtask

    task automatic t_single_write;   // R5 R6
        setup(1, 1);
        bus_wr(8'h02, 8'h11, 1, 8'h99);
        chk(rg(2) === 8'h11, "R5 second strobe ignored", rg(2), 8'h11);
        bus_wr(8'h02, 8'h22);
        chk(rg(2) === 8'h22, "R5 fresh select writes", rg(2), 8'h22);
        ad_in = 8'h77; wr_ds = 0; w(); wr_ds = 1; w();
        chk(rg(2) === 8'h22, "R6 no select no write", rg(2), 8'h22);
        chk(ad_oe === 1'b0, "R8 idle released", ad_oe, 0);
    endtask

    task automatic t_nonmux;   // R7 R8
        setup(1, 0);
        ale_as = 1;
        addr_in = 5'd3; w(); cs_n = 0; w();
        ad_in = 8'h09; ale_as = 0; w(); ale_as = 1; w();
        ad_in = 8'h6E; wr_ds = 0; w(); wr_ds = 1; w(); cs_n = 1; w();
        chk(rg(3) === 8'h6E, "R7 addr_in used", rg(3), 8'h6E);
        chk(rg(9) === 8'h00, "R7 ale ignored", rg(9), 0);
        bus_rd(8'h03, 8'h6E, "R8 intel nonmux read");
        rd_rw = 0; w();
        chk(ad_oe === 1'b0, "R8 read without select", ad_oe, 0);
        rd_rw = 1;
        setup(0, 0);
        bus_wr(8'h1E, 8'hB4);
        chk(rg(30) === 8'hB4, "R7 moto nonmux write", rg(30), 8'hB4);
        bus_rd(8'h1E, 8'hB4, "R8 moto nonmux read");
    endtask

    initial begin
        fork
            begin
                t_reset; t_intel_mux; t_moto_mux; t_single_write; t_nonmux;
            end
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule